// File: doc/BRIEF.md
# Page-Fault Error Code Generator

This block forms the 32-bit error-code word that goes with an address-translation fault. When the fault strobe is high, it samples the access kind, the privilege level, the outcome of the translation walk, the mode enables, and the protection-key inputs. It computes the code from these and registers it. In the next cycle it raises a one-cycle valid pulse. The code register keeps its value until the next page-fault capture.

Three bits of the code depend on more than the access kind. The fetch bit depends on the execute-blocking enables. The protection-key bit needs several mode conditions, and it reads the rights slot of the page's key. The enclave-violation bit is suppressed when an ordinary paging cause is also reported.

A failed load of the directory-pointer registers is a different kind of fault. For it, the block raises a general-protection pulse, and it neither updates nor reports the code.

Both outputs are plain pulses with no ready signal. The block has no back-pressure. It captures every strobe, so the consumer must take each pulse in the cycle it appears.

Top module: `pf_errcode_gen`

## Requirements
- R1: In a reported code, bit 0 is 1 exactly when the walk did not report not-present. Bit 3 equals the reserved-bit violation input.
- R2: The access kind is encoded as 00 read, 01 write, 10 instruction fetch, and 11 treated as read. Bit 1 is 1 only for a write. Bit 2 equals the user-mode privilege input.
- R3: Bit 4 is 1 only when the access is a fetch and either supervisor execute-blocking is on, or both wide-address mode and no-execute enable are on. Otherwise bit 4 is 0.
- R4: Bit 5 is 0 unless all of these hold: long mode is active, keys are enabled, the access is not a fetch, and the page is a user page.
- R5: If the R4 conditions hold, bit 5 is 1 when either of these is true:
  - The access-disable bit of the page key k is 1. This bit sits at rights position 2k.
  - The write-disable bit of key k is 1, the access is a write, and either write-protect is on or the access is in user mode. The write-disable bit sits at rights position 2k+1.
- R6: Bit 15 is 1 only when all of these hold: the enclave violation input is 1, bit 0 is 1, bit 3 is 0, and bit 5 is 0.
- R7: All bits of the code other than 0 to 5 and 15 are 0.
- R8: A fault strobe without pointer-load failure produces the code and a one-cycle `err_valid` in the next cycle. With no strobe, `err_valid` stays 0 and `err_code` holds its value.
- R9: A strobe with the pointer-load failure input set produces a one-cycle `gp_valid` in the next cycle. It produces no `err_valid` and leaves `err_code` unchanged.
- R10: During reset, and in the first cycle after it, `err_code` is 0 and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault strobe; inputs sampled when high |
| acc_kind | input | 2 | Access kind (00 read, 01 write, 10 fetch, 11 read) |
| user_mode | input | 1 | Access made at user privilege |
| walk_not_present | input | 1 | Walk found a non-present entry |
| walk_rsvd | input | 1 | Walk found a reserved-bit violation |
| cfg_sexec_block | input | 1 | Supervisor execute-blocking enable |
| cfg_wide_addr | input | 1 | Wide physical-address mode |
| cfg_nx_en | input | 1 | No-execute enable |
| cfg_long_act | input | 1 | Long mode active |
| cfg_key_en | input | 1 | Protection keys enabled |
| cfg_wr_protect | input | 1 | Supervisor write-protect enable |
| page_user | input | 1 | Faulting address is a user page |
| page_key | input | 4 | Protection key of the page |
| key_rights | input | 32 | Per-key rights, 2 bits per key |
| enclave_viol | input | 1 | Enclave access-control violation |
| ptr_load_fail | input | 1 | Directory-pointer register load failed |
| err_code | output | 32 | Registered error code |
| err_valid | output | 1 | One-cycle page-fault code pulse |
| gp_valid | output | 1 | One-cycle general-protection pulse |

## Verification
The bench sweeps every combination of the access, privilege, walk, mode, page-user and enclave inputs. Keys and rights vary along the sweep. Each field is compared against an arithmetic model.

A second sweep targets the rights lookup. It walks every key, sets each rights pattern in that key's slot, and fills the other slots with the complement. A design that indexed the wrong slot would then report the key bit wrongly. A design that swapped the access-disable and write-disable positions would also report it wrongly, as would one that ignored write-protect for supervisor writes.

Enclave violations are combined with reserved-bit and key faults. A design that copied the enclave input straight into bit 15 would set bit 15 where it must be 0. Pointer-load failures are checked to leave the previous code in place and to raise only the general-protection pulse. A design that reported them as page faults would raise `err_valid` or change the code.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  localparam int CODE_W   = 32;
  localparam int NUM_KEYS = 16;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_kind_e;

  // Bit positions other logic decodes
  localparam int POS_PRESENT = 0;
  localparam int POS_WRITE   = 1;
  localparam int POS_USER    = 2;
  localparam int POS_RSVD    = 3;
  localparam int POS_FETCH   = 4;
  localparam int POS_KEY     = 5;
  localparam int POS_ENCLAVE = 15;
endpackage

// File: rtl/pfe_fetch_flag.sv
module pfe_fetch_flag (
  input  logic is_fetch,
  input  logic sexec_block,
  input  logic wide_addr,
  input  logic nx_en,
  output logic fetch_flag
);
  logic exec_guarded;

  always_comb begin
    exec_guarded = sexec_block | (wide_addr & nx_en);
    fetch_flag   = is_fetch & exec_guarded;
  end
endmodule

// File: rtl/pfe_key_check.sv
module pfe_key_check #(
  parameter int NUM_KEYS = 16,
  localparam int KEY_W    = $clog2(NUM_KEYS),
  localparam int RIGHTS_W = 2 * NUM_KEYS
) (
  input  logic                long_act,
  input  logic                key_en,
  input  logic                is_fetch,
  input  logic                is_write,
  input  logic                user_mode,
  input  logic                page_user,
  input  logic                wr_protect,
  input  logic [KEY_W-1:0]    key,
  input  logic [RIGHTS_W-1:0] rights,
  output logic                key_flag
);
  logic [NUM_KEYS-1:0] acc_dis;
  logic [NUM_KEYS-1:0] wr_dis;

  // Split the rights word into per-key slots: even bit blocks all access,
  // odd bit blocks writes.
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_slot
    assign acc_dis[k] = rights[2*k];
    assign wr_dis[k]  = rights[2*k+1];
  end

  logic gate_ok;
  logic ad_sel;
  logic wd_sel;
  logic wr_hit;

  always_comb begin
    gate_ok  = long_act & key_en & ~is_fetch & page_user;
    ad_sel   = acc_dis[key];
    wd_sel   = wr_dis[key];
    wr_hit   = wd_sel & is_write & (wr_protect | user_mode);
    key_flag = gate_ok & (ad_sel | wr_hit);
  end
endmodule

// File: rtl/pfe_code_build.sv
module pfe_code_build
  import pfe_pkg::*;
#(
  parameter int CODE_W = pfe_pkg::CODE_W
) (
  input  logic              present,
  input  logic              is_write,
  input  logic              user_mode,
  input  logic              rsvd,
  input  logic              fetch_flag,
  input  logic              key_flag,
  input  logic              enclave_viol,
  output logic [CODE_W-1:0] code
);
  logic enclave_ok;

  always_comb begin
    // An enclave cause is reported only when no ordinary paging cause is.
    enclave_ok = enclave_viol & present & ~rsvd & ~key_flag;
    code                 = '0;
    code[POS_PRESENT]    = present;
    code[POS_WRITE]      = is_write;
    code[POS_USER]       = user_mode;
    code[POS_RSVD]       = rsvd;
    code[POS_FETCH]      = fetch_flag;
    code[POS_KEY]        = key_flag;
    code[POS_ENCLAVE]    = enclave_ok;
  end
endmodule

// File: rtl/pf_errcode_gen.sv
module pf_errcode_gen
  import pfe_pkg::*;
#(
  parameter int CODE_W   = pfe_pkg::CODE_W,
  parameter int NUM_KEYS = pfe_pkg::NUM_KEYS,
  localparam int KEY_W    = $clog2(NUM_KEYS),
  localparam int RIGHTS_W = 2 * NUM_KEYS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flt_valid,
  input  logic [1:0]          acc_kind,
  input  logic                user_mode,
  input  logic                walk_not_present,
  input  logic                walk_rsvd,
  input  logic                cfg_sexec_block,
  input  logic                cfg_wide_addr,
  input  logic                cfg_nx_en,
  input  logic                cfg_long_act,
  input  logic                cfg_key_en,
  input  logic                cfg_wr_protect,
  input  logic                page_user,
  input  logic [KEY_W-1:0]    page_key,
  input  logic [RIGHTS_W-1:0] key_rights,
  input  logic                enclave_viol,
  input  logic                ptr_load_fail,
  output logic [CODE_W-1:0]   err_code,
  output logic                err_valid,
  output logic                gp_valid
);
  acc_kind_e kind;
  logic      is_fetch;
  logic      is_write;
  logic      fetch_flag;
  logic      key_flag;
  logic      take_pf;
  logic      take_gp;
  logic [CODE_W-1:0] code_nxt;

  always_comb begin
    kind     = acc_kind_e'(acc_kind);
    is_fetch = (kind == ACC_FETCH);
    is_write = (kind == ACC_WRITE);
    take_pf  = flt_valid & ~ptr_load_fail;
    take_gp  = flt_valid & ptr_load_fail;
  end

  pfe_fetch_flag u_fetch (
    .is_fetch    (is_fetch),
    .sexec_block (cfg_sexec_block),
    .wide_addr   (cfg_wide_addr),
    .nx_en       (cfg_nx_en),
    .fetch_flag  (fetch_flag)
  );

  pfe_key_check #(.NUM_KEYS(NUM_KEYS)) u_key (
    .long_act   (cfg_long_act),
    .key_en     (cfg_key_en),
    .is_fetch   (is_fetch),
    .is_write   (is_write),
    .user_mode  (user_mode),
    .page_user  (page_user),
    .wr_protect (cfg_wr_protect),
    .key        (page_key),
    .rights     (key_rights),
    .key_flag   (key_flag)
  );

  pfe_code_build #(.CODE_W(CODE_W)) u_build (
    .present      (~walk_not_present),
    .is_write     (is_write),
    .user_mode    (user_mode),
    .rsvd         (walk_rsvd),
    .fetch_flag   (fetch_flag),
    .key_flag     (key_flag),
    .enclave_viol (enclave_viol),
    .code         (code_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_code  <= '0;
      err_valid <= 1'b0;
      gp_valid  <= 1'b0;
    end else begin
      err_valid <= take_pf;
      gp_valid  <= take_gp;
      if (take_pf) err_code <= code_nxt;
    end
  end
endmodule

// File: rtl/pfe_errcode_checker.sv
module pfe_errcode_checker #(
  parameter int CODE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_valid,
  input logic [1:0]        acc_kind,
  input logic              cfg_long_act,
  input logic              cfg_key_en,
  input logic              ptr_load_fail,
  input logic [CODE_W-1:0] err_code,
  input logic              err_valid,
  input logic              gp_valid
);
  a_r8_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(flt_valid) && !$past(ptr_load_fail));

  a_r9_gp_follows_fail: assert property (@(posedge clk) disable iff (!rst_n)
    gp_valid |-> $past(flt_valid) && $past(ptr_load_fail));

  a_r9_code_held_on_gp: assert property (@(posedge clk) disable iff (!rst_n)
    gp_valid |-> $stable(err_code));

  a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_valid && gp_valid));

  a_r6_enclave_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code[15]) |-> (err_code[0] && !err_code[3] && !err_code[5]));

  a_r7_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code[CODE_W-1:16] == '0) && (err_code[14:6] == '0));

  a_r3_fetch_bit_source: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code[4]) |-> ($past(acc_kind) == 2'b10));

  a_r4_key_bit_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code[5]) |->
      ($past(acc_kind) != 2'b10) && $past(cfg_long_act) && $past(cfg_key_en));

  a_r8_code_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flt_valid) |-> $stable(err_code));
endmodule

bind pf_errcode_gen pfe_errcode_checker #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/pf_errcode_gen_test.sv
module pf_errcode_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic        user_mode = 1'b0;
  logic        walk_not_present = 1'b0;
  logic        walk_rsvd = 1'b0;
  logic        cfg_sexec_block = 1'b0;
  logic        cfg_wide_addr = 1'b0;
  logic        cfg_nx_en = 1'b0;
  logic        cfg_long_act = 1'b0;
  logic        cfg_key_en = 1'b0;
  logic        cfg_wr_protect = 1'b0;
  logic        page_user = 1'b0;
  logic [3:0]  page_key = 4'd0;
  logic [31:0] key_rights = 32'd0;
  logic        enclave_viol = 1'b0;
  logic        ptr_load_fail = 1'b0;
  logic [31:0] err_code;
  logic        err_valid;
  logic        gp_valid;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_code = 32'd0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  pf_errcode_gen uut (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model();
    logic fetch, wr, b0, b5, ad, wd;
    logic [31:0] c;
    fetch = (acc_kind == 2'b10);
    wr    = (acc_kind == 2'b01);
    b0    = !walk_not_present;
    ad    = key_rights[2*page_key];
    wd    = key_rights[2*page_key+1];
    b5    = cfg_long_act && cfg_key_en && !fetch && page_user &&
            (ad || (wd && wr && (cfg_wr_protect || user_mode)));
    c     = 32'd0;
    c[0]  = b0;
    c[1]  = wr;
    c[2]  = user_mode;
    c[3]  = walk_rsvd;
    c[4]  = fetch && (cfg_sexec_block || (cfg_wide_addr && cfg_nx_en));
    c[5]  = b5;
    c[15] = enclave_viol && b0 && !walk_rsvd && !b5;
    return c;
  endfunction

  // Drive one strobe (inputs already set), then check the result cycle.
  task automatic fire();
    logic [31:0] exp;
    @(negedge clk);
    chk(err_valid == 1'b0 && gp_valid == 1'b0, "R8 idle pulses", {30'd0, gp_valid, err_valid}, 32'd0);
    chk(err_code == last_code, "R8 idle hold", err_code, last_code);
    exp = model();
    flt_valid = 1'b1;
    @(negedge clk);
    flt_valid = 1'b0;
    chk(err_valid == 1'b1, "R8 valid pulse", {31'd0, err_valid}, 32'd1);
    chk(err_code[0] == exp[0] && err_code[3] == exp[3], "R1", err_code, exp);
    chk(err_code[2:1] == exp[2:1], "R2", err_code, exp);
    chk(err_code[4] == exp[4], "R3", err_code, exp);
    chk(err_code[5] == exp[5], "R4 R5", err_code, exp);
    chk(err_code[15] == exp[15], "R6", err_code, exp);
    chk((err_code & 32'hFFFF_7FC0) == 32'd0, "R7", err_code, 32'd0);
    last_code = err_code;
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    chk(err_code == 32'd0 && !err_valid && !gp_valid, "R10 in reset", err_code, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_code == 32'd0 && !err_valid && !gp_valid, "R10 after reset", err_code, 32'd0);

    // Full sweep of the 14 control/access bits
    for (int i = 0; i < 16384; i++) begin
      logic [13:0] v;
      v = 14'(i);
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      acc_kind         = v[1:0];
      user_mode        = v[2];
      walk_not_present = v[3];
      walk_rsvd        = v[4];
      cfg_sexec_block  = v[5];
      cfg_wide_addr    = v[6];
      cfg_nx_en        = v[7];
      cfg_long_act     = v[8];
      cfg_key_en       = v[9];
      cfg_wr_protect   = v[10];
      page_user        = v[11];
      enclave_viol     = v[12];
      page_key         = v[3:0] ^ v[13:10];
      key_rights       = v[13] ? ~lfsr : lfsr;
      fire();
    end

    // R5 targeted: every key, every slot pattern, complement elsewhere
    cfg_long_act = 1'b1; cfg_key_en = 1'b1; page_user = 1'b1;
    walk_not_present = 1'b0; walk_rsvd = 1'b0; enclave_viol = 1'b1;
    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < 4; p++) begin
        for (int m = 0; m < 8; m++) begin
          logic [31:0] r;
          r = {16{~2'(p)}};
          r[2*k +: 2] = 2'(p);
          page_key       = 4'(k);
          key_rights     = r;
          acc_kind       = m[0] ? 2'b01 : 2'b00;
          user_mode      = m[1];
          cfg_wr_protect = m[2];
          fire();
        end
      end
    end

    // R9: pointer-load failures raise only the general-protection pulse
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      acc_kind = 2'(j); walk_not_present = j[0]; walk_rsvd = 1'b1;
      ptr_load_fail = 1'b1;
      flt_valid = 1'b1;
      @(negedge clk);
      flt_valid = 1'b0;
      ptr_load_fail = 1'b0;
      chk(gp_valid == 1'b1, "R9 gp pulse", {31'd0, gp_valid}, 32'd1);
      chk(err_valid == 1'b0, "R9 no code pulse", {31'd0, err_valid}, 32'd0);
      chk(err_code == last_code, "R9 code unchanged", err_code, last_code);
      @(negedge clk);
      chk(gp_valid == 1'b0, "R9 gp one cycle", {31'd0, gp_valid}, 32'd0);
    end

    // R8: idle stretch leaves everything still
    repeat (5) begin
      @(negedge clk);
      chk(!err_valid && !gp_valid && err_code == last_code, "R8 long idle", err_code, last_code);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule